// File: doc/BRIEF.md
# Serial Output Launch Advancement

This block moves the launch of serial time-division-multiplexed output streams earlier than the nominal bit boundary, so that output buffer and board delay can be offset. It sits between the switching core, which provides the nominal stream, and the output pins. It covers every output stream, whether backplane-facing or local, with one common setting. The block is clocked at the system clock rate (131.072 MHz nominal). A two-bit setting selects 0, 1, 2 or 3 steps of advancement. The size of a step depends on the stream rate: one clock cycle on the fast (32 Mb/s) streams, and two clock cycles (about 15 ns) on the slow (16 Mb/s) streams.

Internally, the nominal streams and the frame pulse pass through a fixed delay of `MAXC` cycles. `MAXC` is the largest advancement in cycles, 6 by default. The delayed frame pulse is brought out as the reference frame boundary. Each data stream is read from a tap `MAXC - adv` cycles deep, so its bits leave `adv` cycles ahead of the reference. A bit-phase counter is preloaded at every frame pulse and marks the start of each advanced bit.

A new setting is captured only together with a frame pulse. It takes over at the boundary of the new frame's first bit. When the advancement grows, the last bit of the old frame is cut short. When it shrinks, that last bit is held longer. No bit of the new frame is skipped or repeated.

Top module: `out_bit_advance`

## Requirements
- R1: `frm_ref_o` is high exactly in the cycle `MAXC` clock edges after the edge that sampled `frm_i` high, with `MAXC` = 3 × the larger step size (6 by default).
- R2: Once a setting is in force, `dat_o` after edge n equals `nom_i` sampled at edge n − (`MAXC` − A). A is `adv_sel_i` (binary 0 to 3) times the step, and the step is 1 cycle when `fast_i` = 1 and 2 cycles when `fast_i` = 0.
- R3: After reset and before the first frame pulse, the advancement is zero: `dat_o` after edge n equals `nom_i` from edge n − `MAXC`, the same alignment as `frm_ref_o`.
- R4: `adv_sel_i` and `fast_i` are sampled only at an edge where `frm_i` is high. Values they take in any other cycle do not affect `dat_o` or `bit_start_o`.
- R5: For a frame pulse at edge F that raises the advancement from tap T_old to a smaller tap T_new, `dat_o` switches to the new tap after edge F + T_new. The new frame's first bit (sampled at F) therefore appears there, and the old frame's last bit is shortened by T_old − T_new cycles.
- R6: When the advancement shrinks (T_new > T_old), the tap switches after edge F + T_old. The old frame's last bit is lengthened by T_new − T_old cycles, and the new frame's first bit still appears after edge F + T_new.
- R7: `bit_start_o` is high after edge F + T_new (the new frame's first bit) and then every P cycles until the next frame pulse. P is 4 cycles when `fast_i` was 1 at the frame pulse and 8 cycles when it was 0.
- R8: All `NSTREAM` streams use the same tap in every cycle.
- R9: While `rst_n` is low, `dat_o`, `frm_ref_o` and `bit_start_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_i | input | 1 | Nominal frame pulse, one cycle wide, coincident with the first bit of the frame on `nom_i` |
| adv_sel_i | input | 2 | Advancement in steps (0 to 3), sampled with `frm_i` |
| fast_i | input | 1 | 1 = fast stream rate (1-cycle step, 4-cycle bit); 0 = slow rate (2-cycle step, 8-cycle bit); sampled with `frm_i` |
| nom_i | input | NSTREAM | Nominal serial bit per stream, one sample per clock |
| dat_o | output | NSTREAM | Advanced serial output per stream |
| frm_ref_o | output | 1 | Reference frame boundary, `frm_i` delayed by `MAXC` cycles |
| bit_start_o | output | 1 | Marks the first cycle of each advanced bit |

## Verification
Four properties are checked on every cycle:
- the reference frame pulse keeps its fixed `MAXC`-cycle lag;
- each output bit comes from the tap that the control logic selects;
- a tap change happens only within `MAXC` cycles after a frame pulse;
- the advanced first-bit strobe, with the tap the requested setting implies, appears exactly `MAXC` − A cycles after the frame pulse.

Other behaviours need the bench's scenarios:
- the direction of each transition, whether the old last bit is shortened or lengthened, in both rate modes;
- that setting inputs which change between frame pulses have no effect;
- the bit period of the strobe;
- the reset values.

// File: rtl/obadv_pkg.sv
package obadv_pkg;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Advancement in clock cycles for a step count and rate.
    function automatic int unsigned adv_cycles(input logic [1:0] sel, input logic fast,
                                               input int unsigned step_fast,
                                               input int unsigned step_slow);
        return 32'(sel) * (fast ? step_fast : step_slow);
    endfunction

endpackage

// File: rtl/obadv_tap_ctrl.sv
// Chooses the delay-line tap. A new setting is captured with the frame pulse
// and applied min(old, new) cycles later, so that nothing is skipped or repeated.
module obadv_tap_ctrl
    import obadv_pkg::*;
#(
    parameter int STEP_FAST = 1,
    parameter int STEP_SLOW = 2,
    parameter int MAXC      = 6,
    parameter int TAPW      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_i,
    input  logic [1:0]      adv_sel_i,
    input  logic            fast_i,
    output logic [TAPW-1:0] tap_o,
    output logic [TAPW-1:0] new_tap_o
);

    typedef struct packed {
        logic [TAPW-1:0] tap;
        logic [TAPW-1:0] pend;
        logic [TAPW-1:0] cnt;
        logic            armed;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [TAPW-1:0] newt;
    logic [TAPW-1:0] wait_cyc;

    always_comb begin
        newt     = TAPW'(MAXC - adv_cycles(adv_sel_i, fast_i, STEP_FAST, STEP_SLOW));
        wait_cyc = (st_q.tap < newt) ? st_q.tap : newt;
        st_d     = st_q;
        if (frm_i) begin
            if (wait_cyc == '0) begin
                st_d.tap   = newt;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b1;
                st_d.cnt   = wait_cyc;
                st_d.pend  = newt;
            end
        end else if (st_q.armed) begin
            if (st_q.cnt == TAPW'(1)) begin
                st_d.tap   = st_q.pend;
                st_d.armed = 1'b0;
            end
            st_d.cnt = st_q.cnt - TAPW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tap   <= TAPW'(MAXC);
            st_q.pend  <= TAPW'(MAXC);
            st_q.cnt   <= '0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_o     = st_q.tap;
    assign new_tap_o = newt;

endmodule

// File: rtl/obadv_bit_phase.sv
// Counts down the bit period. Preloaded at the frame pulse so that the
// count reaches zero on the advanced first bit.
module obadv_bit_phase
    import obadv_pkg::*;
#(
    parameter int BITC_FAST = 4,
    parameter int BITC_SLOW = 8,
    parameter int TAPW      = 3,
    parameter int PHW       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TAPW-1:0] load_val_i,
    input  logic            fast_i,
    output logic            strobe_o
);

    typedef struct packed {
        logic [PHW-1:0] ph;
        rate_e          rate;
    } ph_t;

    ph_t st_d, st_q;
    logic [PHW-1:0] last;

    always_comb begin
        last = (st_q.rate == RATE_FAST) ? PHW'(BITC_FAST - 1) : PHW'(BITC_SLOW - 1);
        st_d = st_q;
        if (load_i) begin
            st_d.ph   = PHW'(load_val_i);
            st_d.rate = rate_e'(fast_i);
        end else if (st_q.ph == '0) begin
            st_d.ph = last;
        end else begin
            st_d.ph = st_q.ph - PHW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PHW'(BITC_SLOW - 1);
            st_q.rate <= RATE_SLOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = (st_q.ph == '0);

endmodule

// File: rtl/obadv_delay_line.sv
// Fixed-length history of the nominal streams and the frame pulse. The output
// of every stream is read at the tap that is currently selected.
module obadv_delay_line #(
    parameter int NSTREAM = 4,
    parameter int DEPTH   = 7,
    parameter int TAPW    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSTREAM-1:0] nom_i,
    input  logic               frm_i,
    input  logic [TAPW-1:0]    tap_i,
    output logic [NSTREAM-1:0] dat_o,
    output logic               frm_ref_o
);

    typedef struct packed {
        logic [NSTREAM-1:0][DEPTH-1:0] hist;
        logic [DEPTH-1:0]              fh;
    } dl_t;

    dl_t st_d, st_q;

    always_comb begin
        for (int s = 0; s < NSTREAM; s++) begin
            st_d.hist[s] = {st_q.hist[s][DEPTH-2:0], nom_i[s]};
        end
        st_d.fh = {st_q.fh[DEPTH-2:0], frm_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSTREAM; g++) begin : g_tap
        assign dat_o[g] = st_q.hist[g][tap_i];
    end

    assign frm_ref_o = st_q.fh[DEPTH-1];

endmodule

// File: rtl/out_bit_advance.sv
module out_bit_advance
    import obadv_pkg::*;
#(
    parameter int NSTREAM   = 4,
    parameter int STEP_FAST = 1,
    parameter int STEP_SLOW = 2,
    parameter int BITC_FAST = 4,
    parameter int BITC_SLOW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_i,
    input  logic [1:0]         adv_sel_i,
    input  logic               fast_i,
    input  logic [NSTREAM-1:0] nom_i,
    output logic [NSTREAM-1:0] dat_o,
    output logic               frm_ref_o,
    output logic               bit_start_o
);

    localparam int MAXC  = 3 * int'(max2(STEP_FAST, STEP_SLOW));
    localparam int DEPTH = MAXC + 1;
    localparam int TAPW  = $clog2(DEPTH);
    localparam int PHW   = $clog2(int'(max2(max2(BITC_FAST, BITC_SLOW), DEPTH)));

    logic [TAPW-1:0] tap;
    logic [TAPW-1:0] new_tap;

    obadv_tap_ctrl #(
        .STEP_FAST(STEP_FAST),
        .STEP_SLOW(STEP_SLOW),
        .MAXC     (MAXC),
        .TAPW     (TAPW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_i    (frm_i),
        .adv_sel_i(adv_sel_i),
        .fast_i   (fast_i),
        .tap_o    (tap),
        .new_tap_o(new_tap)
    );

    obadv_bit_phase #(
        .BITC_FAST(BITC_FAST),
        .BITC_SLOW(BITC_SLOW),
        .TAPW     (TAPW),
        .PHW      (PHW)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (frm_i),
        .load_val_i(new_tap),
        .fast_i    (fast_i),
        .strobe_o  (bit_start_o)
    );

    obadv_delay_line #(
        .NSTREAM(NSTREAM),
        .DEPTH  (DEPTH),
        .TAPW   (TAPW)
    ) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .nom_i    (nom_i),
        .frm_i    (frm_i),
        .tap_i    (tap),
        .dat_o    (dat_o),
        .frm_ref_o(frm_ref_o)
    );

endmodule

// File: rtl/obadv_chk.sv
module obadv_chk
    import obadv_pkg::*;
#(
    parameter int NSTREAM   = 4,
    parameter int STEP_FAST = 1,
    parameter int STEP_SLOW = 2,
    parameter int MAXC      = 6,
    parameter int TAPW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frm_i,
    input logic [1:0]         adv_sel_i,
    input logic               fast_i,
    input logic [NSTREAM-1:0] nom_i,
    input logic [NSTREAM-1:0] dat_o,
    input logic               frm_ref_o,
    input logic               bit_start_o,
    input logic [TAPW-1:0]    tap
);

    logic [MAXC:0][NSTREAM-1:0] nh_q;
    logic [MAXC:0]              fh_q;
    logic [7:0]                 since_q;
    logic [7:0]                 ecnt_q;
    logic [TAPW-1:0]            etap_q;
    logic                       earm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nh_q    <= '0;
            fh_q    <= '0;
            since_q <= 8'hff;
            ecnt_q  <= '0;
            etap_q  <= '0;
            earm_q  <= 1'b0;
        end else begin
            nh_q <= {nh_q[MAXC-1:0], nom_i};
            fh_q <= {fh_q[MAXC-1:0], frm_i};
            if (frm_i) begin
                since_q <= '0;
            end else if (since_q != 8'hff) begin
                since_q <= since_q + 8'd1;
            end
            if (frm_i) begin
                earm_q <= 1'b1;
                ecnt_q <= 8'(MAXC - adv_cycles(adv_sel_i, fast_i, STEP_FAST, STEP_SLOW) + 1);
                etap_q <= TAPW'(MAXC - adv_cycles(adv_sel_i, fast_i, STEP_FAST, STEP_SLOW));
            end else if (earm_q) begin
                if (ecnt_q == 8'd1) earm_q <= 1'b0;
                ecnt_q <= ecnt_q - 8'd1;
            end
        end
    end

    // R1: reference frame boundary lags frm_i by MAXC edges
    p_ref_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ref_o == fh_q[MAXC]);

    // R2, R8: every stream is read from the tap the controller selects
    p_data_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dat_o == nh_q[tap]);

    // R4: the tap moves only shortly after a frame pulse
    p_tap_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap) |-> (since_q <= 8'(MAXC)));

    // R5, R7: advanced first bit is marked and uses the requested tap
    p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (earm_q && ecnt_q == 8'd1) |-> (bit_start_o && tap == etap_q));

endmodule

bind out_bit_advance obadv_chk #(
    .NSTREAM  (NSTREAM),
    .STEP_FAST(STEP_FAST),
    .STEP_SLOW(STEP_SLOW),
    .MAXC     (MAXC),
    .TAPW     (TAPW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_i      (frm_i),
    .adv_sel_i  (adv_sel_i),
    .fast_i     (fast_i),
    .nom_i      (nom_i),
    .dat_o      (dat_o),
    .frm_ref_o  (frm_ref_o),
    .bit_start_o(bit_start_o),
    .tap        (tap)
);

// File: tb/out_bit_advance_test.sv
module out_bit_advance_test;

    localparam int NS      = 4;
    localparam int MAXC    = 6;
    localparam int FR      = 64;
    localparam int NFR     = 10;
    localparam int FIRST   = 20;
    localparam int HORIZON = FIRST + FR * NFR + 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frm;
    logic [1:0]    adv;
    logic          fast;
    logic [NS-1:0] nom;
    logic [NS-1:0] dat_o;
    logic          frm_ref_o;
    logic          bit_start_o;

    always #4 clk = ~clk;

    out_bit_advance #(.NSTREAM(NS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_i      (frm),
        .adv_sel_i  (adv),
        .fast_i     (fast),
        .nom_i      (nom),
        .dat_o      (dat_o),
        .frm_ref_o  (frm_ref_o),
        .bit_start_o(bit_start_o)
    );

    typedef struct {
        logic [NS-1:0] dat;
        logic          fref;
        logic          bs;
        bit            bs_chk;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   compared   = 0;
    int   mismatched = 0;
    bit   done       = 1'b0;

    logic [NS-1:0] nomh [HORIZON];
    logic          frmh [HORIZON];
    logic [1:0]    adv_s  [NFR];
    logic          fast_s [NFR];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Monitor: compares each cycle's outputs against the scoreboard entry.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, 32'(dat_o), 32'(e.dat));
                chk("R1 frame ref", 32'(frm_ref_o), 32'(e.fref));
                if (e.bs_chk) chk("R7 bit start", 32'(bit_start_o), 32'(e.bs));
            end
        end
    end

    // Driver plus expected-value model.
    initial begin
        int  tap_cur, old_t, new_t, last_f, per, tap_n, src, kf;
        bit  seen;
        exp_t e;

        // taps: 6,4,0,2,6 (slow) then 3,5,4,6 (fast) then 0 (slow)
        adv_s  = '{2'd0, 2'd1, 2'd3, 2'd2, 2'd0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd3};
        fast_s = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

        rst_n = 1'b0; frm = 1'b0; adv = 2'd0; fast = 1'b0; nom = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset dat", 32'(dat_o), 32'd0);
        chk("R9 reset ref", 32'(frm_ref_o), 32'd0);
        chk("R9 reset strobe", 32'(bit_start_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        tap_cur = MAXC; old_t = MAXC; new_t = MAXC; last_f = -1000; per = 8; seen = 1'b0;
        for (int n = 0; n < HORIZON; n++) begin
            bit is_f;
            kf   = (n - FIRST) / FR;
            is_f = (n >= FIRST) && (((n - FIRST) % FR) == 0) && (kf < NFR);
            nom  = NS'($urandom);
            frm  = is_f;
            if (is_f) begin
                adv  = adv_s[kf];
                fast = fast_s[kf];
            end else begin
                adv  = 2'($urandom);   // R4: ignored between frame pulses
                fast = 1'($urandom);
            end
            nomh[n] = nom;
            frmh[n] = frm;

            if (is_f) begin
                old_t  = tap_cur;
                new_t  = MAXC - int'(adv) * (fast ? 1 : 2);
                last_f = n;
                per    = fast ? 4 : 8;
                seen   = 1'b1;
            end
            tap_n   = (seen && n >= last_f + imin(old_t, new_t)) ? new_t : old_t;
            tap_cur = tap_n;

            src   = n - tap_n;
            e.dat = (src >= 0) ? nomh[src] : '0;
            e.fref = (n - MAXC >= 0) ? frmh[n - MAXC] : 1'b0;
            if (!seen)
                e.tag = "R3 default alignment";
            else if (old_t != new_t && n < last_f + imax(old_t, new_t))
                e.tag = (new_t < old_t) ? "R5 advance grows" : "R6 advance shrinks";
            else
                e.tag = "R2 R4 R8 steady data";
            e.bs_chk = seen && (n >= last_f + new_t);
            e.bs     = e.bs_chk && (((n - last_f - new_t) % per) == 0);
            q.push_back(e);
            @(negedge clk);
        end
        frm = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule